// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the memory address for every cycle of a four-beat burst access. When a new access starts, the full external address is captured. Its two lowest bits become the starting point of a small burst counter. On each later cycle in which the advance input is active, the counter moves to the next beat. The low two address bits then follow either a linear order (add one, modulo four) or an interleaved order (start value XOR beat number). The order is chosen at run time by a select input. The upper address bits never change between loads.

The counter stores the start value and a separate 2-bit beat number. The output address is formed from these two values. Because of this, the wrap back to the start value on the fifth beat is the same in both orders. The beat number is also an output, so surrounding logic or a bench can index a reference table.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, the address output is zero and the beat output is zero.
- R2: A cycle with `load_i` high captures `ext_addr_i` on that clock edge. From the next cycle, `addr_o` equals the captured address and `beat_o` is 0.
- R3: With `linear_i` high (linear order), the low two bits of `addr_o` equal (start + beat) modulo 4.
- R4: With `linear_i` low (interleaved order), the low two bits of `addr_o` equal start XOR beat.
- R5: A cycle with `load_i` low and `adv_n_i` low increments `beat_o` by one, modulo 4, at the clock edge.
- R6: A cycle with `load_i` low and `adv_n_i` high leaves `addr_o` and `beat_o` unchanged.
- R7: `load_i` takes priority over `adv_n_i`. A load with advance active still restarts at beat 0 from the new address.
- R8: Bits above bit 1 of `addr_o` stay equal to the loaded upper bits until the next load.
- R9: After four advances, the beat and the address return to their values at the load, in either order.
- R10: Changing `linear_i` in the middle of a burst changes only the address mapping. The beat count is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst from ext_addr_i |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| linear_i | input | 1 | 1 = linear order, 0 = interleaved order |
| ext_addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Address for the current beat |
| beat_o | output | 2 | Beat number within the burst |

## Verification
On every cycle, the embedded assertions check the following:
- the beat step and the hold on advance and on idle;
- the restart at beat 0 after a load;
- that the upper bits are constant between loads;
- that the low bits match the selected order formula.

Only the bench scenarios show the following:
- the exact address sequence for each start value in both orders;
- the return to the start value on the fifth beat;
- loads placed over an active advance;
- an order change partway through a burst.

A seeded random mix of loads, advances and order changes is compared against a bench-side model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   localparam int unsigned BEAT_W = 2;
   typedef logic [BEAT_W-1:0] beat_t;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } order_e;

   function automatic beat_t map_low(input beat_t start, input beat_t beat, input order_e ord);
      return (ord == ORD_LINEAR) ? beat_t'(start + beat) : (start ^ beat);
   endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_addr_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  load_i,
   input  logic  adv_n_i,
   output beat_t beat_o
);
   beat_t beat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       beat_q <= '0;
      else if (load_i)   beat_q <= '0;
      else if (!adv_n_i) beat_q <= beat_q + beat_t'(1);
   end

   assign beat_o = beat_q;

   // R5
   beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !adv_n_i) |=> beat_o == beat_t'($past(beat_o) + 1));
   // R6
   beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && adv_n_i) |=> $stable(beat_o));
   // R7
   beat_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> beat_o == '0);
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] ext_addr_i,
   output logic [ADDR_W-1:0] base_o
);
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     base_q <= '0;
      else if (load_i) base_q <= ext_addr_i;
   end

   assign base_o = base_q;

   // R2
   base_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> base_o == $past(ext_addr_i));
   // R8
   base_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(base_o));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              adv_n_i,
   input  logic              linear_i,
   input  logic [ADDR_W-1:0] ext_addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        beat_o
);
   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   initial begin
      addr_w_chk: assert (ADDR_W > BEAT_W) else $error("ADDR_W must exceed 2");
   end

   logic [ADDR_W-1:0] base;
   beat_t             beat;
   order_e            ord;

   assign ord = linear_i ? ORD_LINEAR : ORD_INTERLEAVE;

   burst_addr_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
      .ext_addr_i(ext_addr_i), .base_o(base)
   );

   burst_beat_ctr u_beat (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
      .adv_n_i(adv_n_i), .beat_o(beat)
   );

   generate
      if (HI_W > 0) begin : g_hi
         assign addr_o = {base[ADDR_W-1:BEAT_W], map_low(base[BEAT_W-1:0], beat, ord)};
      end
   endgenerate

   assign beat_o = beat;

   // R3
   linear_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      linear_i |-> addr_o[1:0] == 2'(base[1:0] + beat_o));
   // R4
   inter_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !linear_i |-> addr_o[1:0] == (base[1:0] ^ beat_o));
   // R8
   upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
   localparam int AW = 20;
   logic clk = 0, rst_n = 0, load = 0, adv_n = 1, lin = 0;
   logic [AW-1:0] ext = '0;
   logic [AW-1:0] addr;
   logic [1:0] beat;
   int n_run = 0, n_fail = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0] m_beat = '0;

   always #2 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) dut (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .adv_n_i(adv_n),
      .linear_i(lin), .ext_addr_i(ext), .addr_o(addr), .beat_o(beat)
   );

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [1:0] n, input logic l);
      logic [1:0] lo = l ? 2'(b[1:0] + n) : (b[1:0] ^ n);
      return {b[AW-1:2], lo};
   endfunction

   task automatic check(input string req);
      logic [AW-1:0] e = exp_addr(m_base, m_beat, lin);
      n_run++;
      if (addr !== e || beat !== m_beat) begin
         n_fail++;
         $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d", req, addr, beat, e, m_beat);
      end
   endtask

   task automatic step(input logic ld, input logic an, input logic [AW-1:0] a);
      load = ld; adv_n = an; ext = a;
      @(posedge clk);
      if (ld) begin m_base = a; m_beat = '0; end
      else if (!an) m_beat = m_beat + 2'd1;
      #1;
      load = 0; adv_n = 1;
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] hold_a;
      logic [1:0] hold_b;
      void'($urandom(32'h1234));
      #7;
      check("R1");
      rst_n = 1;
      @(negedge clk);
      // R2, R4: interleaved order, start value 01
      lin = 0;
      step(1, 1, 20'hABCD1); check("R2");
      for (int i = 0; i < 4; i++) begin step(0, 0, '0); check("R4"); end
      check("R9");
      // R3: linear order for every start value, with the wrap
      lin = 1;
      for (int s = 0; s < 4; s++) begin
         step(1, 1, {18'h2F0F0, 2'(s)}); check("R3");
         for (int i = 0; i < 4; i++) begin step(0, 0, '0); check("R3"); end
         if (addr !== {18'h2F0F0, 2'(s)}) begin n_fail++; $display("FAIL R9 addr=%h expected=%h", addr, {18'h2F0F0, 2'(s)}); end
         n_run++;
      end
      // R6: an idle cycle holds the address and beat
      step(1, 1, 20'h00002); step(0, 0, '0);
      hold_a = addr; hold_b = beat;
      step(0, 1, 20'hFFFFF); step(0, 1, 20'h12345);
      n_run++;
      if (addr !== hold_a || beat !== hold_b) begin n_fail++; $display("FAIL R6 addr=%h beat=%0d expected addr=%h beat=%0d", addr, beat, hold_a, hold_b); end
      check("R8");
      // R7: a load issued together with an active advance
      step(0, 0, '0);
      step(1, 0, 20'h55557); check("R7");
      // R10: change the order in the middle of a burst
      step(0, 0, '0); step(0, 0, '0);
      lin = 0; #1; check("R10");
      lin = 1; #1; check("R10");
      // random mix of loads, advances and order changes
      for (int i = 0; i < 3000; i++) begin
         lin = 1'($urandom);
         step(($urandom % 5) == 0, 1'($urandom), AW'($urandom));
         check("R5");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule